// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Selectable Drive Styles

This block is one general-purpose I/O port of eight pins. It sits behind a small 32-bit register bus with a write strobe, a read strobe, an offset, write data and read data. For each pin, software sets three things: an output bit, a two-bit pin mode and a flag that turns the pull-up off. The pin mode either leaves the pin as an input or picks one of three output drive styles: push-pull, open-drain or open-source.

The port drives three signals per pad: output enable, output value and pull-up enable. Pad levels come back through a two-flop synchroniser, and software reads them from a read-only level register. Whether a pad is driven depends on both the pin mode and the output bit. Because of this, a wired-AND or wired-OR bus can be built by setting a mode once and then toggling only the data bits.

The asynchronous active-low reset is released in step with the clock. After reset every pin is an input, the output data is zero and every pull-up is on.

Top module: `gpio_drive_port`

## Requirements
- R1: After reset all pad output enables are 0, all pull-up enables are 1, and the data (0x08), mode (0x0C) and pull (0x10) registers read as zero.
- R2: The data register at offset 0x08 holds one bit per pin in bits 7:0. It reads back the last value written, with bits 31:8 reading as zero.
- R3: The mode register at offset 0x0C holds pin n's mode in bits [2n+1:2n] (bits 15:0 in all). It reads back the last value written, with bits 31:16 reading as zero.
- R4: A pin in mode 00 (input) never has its output enable set, whatever its data bit is.
- R5: A pin in mode 01 (push-pull) always has its output enable set, and its pad output equals its data bit.
- R6: A pin in mode 10 (open-drain) is driven only when its data bit is 0, and it is then driven low.
- R7: A pin in mode 11 (open-source) is driven only when its data bit is 1, and it is then driven high.
- R8: The pull register at offset 0x10 has one bit per pin in bits 7:0, where 1 turns that pin's pull-up off. Each pull-up enable is the inverse of its bit, and the register reads back.
- R9: The level register at offset 0x04 returns the pad inputs in bits 7:0. A pad change becomes visible after exactly two rising clock edges. Writes to 0x04 change nothing.
- R10: A read from any other offset returns zero, and a write to any other offset leaves every register unchanged.
- R11: Read data is zero whenever the read strobe is low.
- R12: A register write changes the pad outputs on the same rising edge that captures it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| pad_in | input | 8 | Raw pad levels (asynchronous) |
| pad_oe | output | 8 | Per-pad output enable |
| pad_out | output | 8 | Per-pad output value |
| pad_pu_en | output | 8 | Per-pad pull-up enable |

## Verification
The drive logic is tried with a table of mode and data patterns. In the uniform patterns all pins share one mode, which shows whether each drive style gates the output enable on the right data polarity. The mixed patterns place all four modes side by side and flip the data between all ones and all zeros, which catches a mode field read from the wrong bit pair or a polarity swapped between open-drain and open-source. Directed tests cover the two-edge input latency, writes to the read-only and unmapped offsets, and the edge on which a write reaches the pads.

// File: rtl/gpio_drive_pkg.sv
package gpio_drive_pkg;

  typedef enum logic [1:0] {
    PM_INPUT      = 2'b00,
    PM_PUSHPULL   = 2'b01,
    PM_OPENDRAIN  = 2'b10,
    PM_OPENSOURCE = 2'b11
  } pin_mode_e;

  localparam int MODE_BITS = 2;

  // Register offsets within the port
  localparam logic [7:0] OFS_LEVEL = 8'h04;
  localparam logic [7:0] OFS_DATA  = 8'h08;
  localparam logic [7:0] OFS_MODE  = 8'h0C;
  localparam logic [7:0] OFS_PULL  = 8'h10;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q, meta_d;
  logic [WIDTH-1:0] lvl_q, lvl_d;
  logic [1:0]       primed_q;

  always_comb begin
    meta_d = async_in;
    lvl_d  = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      lvl_q    <= '0;
      primed_q <= 2'b00;
    end else begin
      meta_q   <= meta_d;
      lvl_q    <= lvl_d;
      primed_q <= {primed_q[0], 1'b1};
    end
  end

  assign sync_out = lvl_q;

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q[1] |-> (lvl_q == $past(async_in, 2))) // R9
    else $error("level register lags pads by other than two edges");

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_drive_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [MODE_BITS*NPINS-1:0] wdata,
  input  logic [NPINS-1:0]         level,
  output logic [NPINS-1:0]         dout_q,
  output logic [MODE_BITS*NPINS-1:0] mode_q,
  output logic [NPINS-1:0]         pull_dis_q,
  output logic [DATA_W-1:0]        rdata
);

  localparam int MODE_W = MODE_BITS * NPINS;

  logic hit_level, hit_data, hit_mode, hit_pull;
  logic dout_en, mode_en, pull_en;
  logic [NPINS-1:0]  dout_d, pull_d;
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    hit_level = (addr == ADDR_W'(OFS_LEVEL));
    hit_data  = (addr == ADDR_W'(OFS_DATA));
    hit_mode  = (addr == ADDR_W'(OFS_MODE));
    hit_pull  = (addr == ADDR_W'(OFS_PULL));
    dout_en   = wr && hit_data;
    mode_en   = wr && hit_mode;
    pull_en   = wr && hit_pull;
    dout_d    = wdata[NPINS-1:0];
    mode_d    = wdata[MODE_W-1:0];
    pull_d    = wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q     <= '0;
      mode_q     <= '0;
      pull_dis_q <= '0;
    end else begin
      if (dout_en) dout_q     <= dout_d;
      if (mode_en) mode_q     <= mode_d;
      if (pull_en) pull_dis_q <= pull_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit_level)     rdata = DATA_W'(level);
      else if (hit_data) rdata = DATA_W'(dout_q);
      else if (hit_mode) rdata = DATA_W'(mode_q);
      else if (hit_pull) rdata = DATA_W'(pull_dis_q);
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_data) |=> $stable(dout_q)) // R10
    else $error("data register changed without a write to it");

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_mode) |=> $stable(mode_q)) // R10
    else $error("mode register changed without a write to it");

  AST_LEVEL_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_level) |=> $stable({dout_q, mode_q, pull_dis_q})) // R9
    else $error("write to level offset altered state");

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)) // R11
    else $error("read data nonzero with read strobe low");

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_drive_pkg::*;
(
  input  logic [MODE_BITS-1:0] mode,
  input  logic                 dout,
  input  logic                 pull_dis,
  output logic                 oe,
  output logic                 out,
  output logic                 pu_en
);

  pin_mode_e pm;

  always_comb begin
    pm = pin_mode_e'(mode);
    unique case (pm)
      PM_PUSHPULL: begin
        oe  = 1'b1;
        out = dout;
      end
      PM_OPENDRAIN: begin
        oe  = ~dout;
        out = 1'b0;
      end
      PM_OPENSOURCE: begin
        oe  = dout;
        out = 1'b1;
      end
      default: begin
        oe  = 1'b0;
        out = 1'b0;
      end
    endcase
    pu_en = ~pull_dis;
  end

endmodule

// File: rtl/gpio_drive_port.sv
module gpio_drive_port
  import gpio_drive_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu_en
);

  localparam int MODE_W = MODE_BITS * NPINS;

  logic              rst_sync_n;
  logic [NPINS-1:0]  level;
  logic [NPINS-1:0]  dout_q;
  logic [MODE_W-1:0] mode_q;
  logic [NPINS-1:0]  pull_dis_q;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:MODE_W];

  gpio_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  gpio_in_sync #(.WIDTH(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (level)
  );

  gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata[MODE_W-1:0]),
    .level      (level),
    .dout_q     (dout_q),
    .mode_q     (mode_q),
    .pull_dis_q (pull_dis_q),
    .rdata      (bus_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_pin_drive u_drv (
      .mode     (mode_q[MODE_BITS*i +: MODE_BITS]),
      .dout     (dout_q[i]),
      .pull_dis (pull_dis_q[i]),
      .oe       (pad_oe[i]),
      .out      (pad_out[i]),
      .pu_en    (pad_pu_en[i])
    );

    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mode_q[MODE_BITS*i +: MODE_BITS] == PM_INPUT) |-> !pad_oe[i]) // R4
      else $error("input-mode pin driven");

    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mode_q[MODE_BITS*i +: MODE_BITS] == PM_OPENDRAIN && pad_oe[i]) |-> !pad_out[i]) // R6
      else $error("open-drain pin driven high");

    AST_OS_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (mode_q[MODE_BITS*i +: MODE_BITS] == PM_OPENSOURCE && pad_oe[i]) |-> pad_out[i]) // R7
      else $error("open-source pin driven low");
  end

  AST_PULL_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'(OFS_PULL)) |=>
      (pad_pu_en == ~$past(bus_wdata[NPINS-1:0]))) // R8
    else $error("pull-up enables do not follow pull register write");

endmodule

// File: tb/gpio_drive_port_tb.sv
`timescale 1ns/1ps
module gpio_drive_port_tb;

  localparam time CLK_PERIOD = 8ns;
  localparam logic [7:0] A_LEVEL = 8'h04;
  localparam logic [7:0] A_DATA  = 8'h08;
  localparam logic [7:0] A_MODE  = 8'h0C;
  localparam logic [7:0] A_PULL  = 8'h10;
  localparam int NVEC = 6;

  // {mode[15:0], data[7:0], expected oe[7:0], expected driven value[7:0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h0000, 8'hFF, 8'h00, 8'h00},  // R4 all input
    {16'h5555, 8'hA5, 8'hFF, 8'hA5},  // R5 all push-pull
    {16'hAAAA, 8'hA5, 8'h5A, 8'h00},  // R6 all open-drain
    {16'hFFFF, 8'hA5, 8'hA5, 8'hA5},  // R7 all open-source
    {16'hE4E4, 8'hFF, 8'hAA, 8'hAA},  // mixed, data high
    {16'hE4E4, 8'h00, 8'h66, 8'h00}   // mixed, data low
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  pad_in, pad_oe, pad_out, pad_pu_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_drive_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu_en (pad_pu_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pad_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", 32'(pad_oe), 32'h00);
    chk("R1 pu_en", 32'(pad_pu_en), 32'hFF);
    bus_read(A_DATA, rv); chk("R1 data", rv, 32'h0);
    bus_read(A_MODE, rv); chk("R1 mode", rv, 32'h0);
    bus_read(A_PULL, rv); chk("R1 pull", rv, 32'h0);

    // R11 no read strobe gives zero
    @(negedge clk); bus_addr = A_PULL; #1;
    chk("R11 idle rdata", bus_rdata, 32'h0);

    // Table of drive patterns: R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      bus_write(A_MODE, {16'hFFFF, VEC[k][39:24]});
      bus_write(A_DATA, {24'hFFFFFF, VEC[k][23:16]});
      #1;
      chk($sformatf("R4/R5/R6/R7 oe vec%0d", k), 32'(pad_oe), 32'(VEC[k][15:8]));
      chk($sformatf("R4/R5/R6/R7 out vec%0d", k), 32'(pad_out & pad_oe), 32'(VEC[k][7:0]));
    end

    // R2 data readback with upper bits dropped
    bus_write(A_DATA, 32'hFFFF_FF3C);
    bus_read(A_DATA, rv); chk("R2 data readback", rv, 32'h3C);

    // R3 mode readback with upper bits dropped
    bus_write(A_MODE, 32'hFFFF_1B2D);
    bus_read(A_MODE, rv); chk("R3 mode readback", rv, 32'h1B2D);

    // R8 pull-up disable
    bus_write(A_PULL, 32'hFFFF_FF0F);
    #1 chk("R8 pu_en", 32'(pad_pu_en), 32'hF0);
    bus_read(A_PULL, rv); chk("R8 pull readback", rv, 32'h0F);

    // R9 two-edge input latency
    @(negedge clk);
    pad_in = 8'h96; bus_rd = 1'b1; bus_addr = A_LEVEL;
    @(negedge clk); #1 chk("R9 after one edge", bus_rdata, 32'h00);
    @(negedge clk); #1 chk("R9 after two edges", bus_rdata, 32'h96);
    bus_rd = 1'b0;

    // R9 writes to level offset change nothing
    bus_write(A_LEVEL, 32'hFFFF_FFFF);
    bus_read(A_LEVEL, rv); chk("R9 level after write", rv, 32'h96);
    bus_read(A_DATA, rv);  chk("R9 data untouched", rv, 32'h3C);
    bus_read(A_MODE, rv);  chk("R9 mode untouched", rv, 32'h1B2D);

    // R10 unmapped offset
    bus_write(8'h20, 32'hFFFF_FFFF);
    bus_read(8'h20, rv);  chk("R10 unmapped read", rv, 32'h0);
    bus_read(A_DATA, rv); chk("R10 data untouched", rv, 32'h3C);
    bus_read(A_PULL, rv); chk("R10 pull untouched", rv, 32'h0F);
    #1 chk("R10 pu_en untouched", 32'(pad_pu_en), 32'hF0);

    // R12 pads change on the capturing edge only
    bus_write(A_MODE, 32'h0000_5555);
    bus_write(A_DATA, 32'h0000_0000);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = 32'h0000_00C3;
    #1 chk("R12 before edge", 32'(pad_out), 32'h00);
    @(posedge clk); #1 chk("R12 after edge", 32'(pad_out), 32'hC3);
    @(negedge clk); bus_wr = 1'b0;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule